// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one block-transfer request into a stream of word beats. A request names a base address, a 16-bit mask of registers, one of four addressing modes and whether the base is to be updated. For every set bit in the mask, the block emits one beat. Each beat carries a word address and a register number, and moves on a valid/ready handshake. After the last beat it can present the updated base value for one cycle.

Registers always leave in ascending number order, and the lowest-numbered register goes to the lowest address. The mode only selects where the address window starts and in which direction the base moves. Stack operations map onto the modes as follows:
- Push onto a full descending stack uses decrement-before.
- Pop from a full descending stack uses increment-after.
- Pop from a full ascending stack uses decrement-after.

Memory access and data movement happen outside the block.

Top module: `lsm_addr_seq`

## Requirements
- R1: During and right after reset, `busy_o`, `beat_valid_o` and `wb_valid_o` are low.
- R2: `mode_i` encoding is 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before. The first beat's address is the base in mode 0 and base+4 in mode 1.
- R3: With N set bits, the first beat's address is base−4N in mode 3 and base−4N+4 in mode 2.
- R4: One beat is issued for each set mask bit, in ascending register order. Each accepted beat is followed by the next one at an address 4 higher.
- R5: While `beat_valid_o` is high and `beat_ready_i` is low, the beat's address, register number and valid stay unchanged.
- R6: With writeback requested, `wb_valid_o` pulses for exactly one cycle, in the cycle after the last beat is accepted, and never alongside a beat. `wb_base_o` is then base+4N (modes 0, 1) or base−4N (modes 2, 3). Without writeback there is no pulse.
- R7: An empty mask produces no beats. With writeback requested, the value presented is the unchanged base.
- R8: `start_i` is ignored while `busy_o` is high.
- R9: `beat_last_o` is high on the final beat only. After that beat is accepted, no further beat is issued.
- R10: A decrement-after sequence issued after an increment-before sequence of the same mask covers the same addresses and restores the original base. A full-descending push (mode 3) from 0x00080014 with two registers writes back 0x0008000C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| base_i | input | 32 | Base address |
| reg_list_i | input | 16 | Register mask, bit i = register i |
| mode_i | input | 2 | Addressing mode (see R2) |
| wb_en_i | input | 1 | Request base update |
| busy_o | output | 1 | Sequence in progress |
| beat_valid_o | output | 1 | Beat offered |
| beat_ready_i | input | 1 | Beat accepted by consumer |
| beat_addr_o | output | 32 | Beat word address |
| beat_reg_o | output | 4 | Beat register number |
| beat_last_o | output | 1 | Final beat of the sequence |
| wb_valid_o | output | 1 | Updated base present (one cycle) |
| wb_base_o | output | 32 | Updated base value |

## Verification
There are three ways a wrong internal state can show at the ports:
- A corrupted remaining-register mask shows in the first cycle after the next accepted beat: the register number skips or repeats, or the beat count is wrong at the end of the sequence.
- A wrong address register shows on the very next beat as a step other than 4.
- A wrong latched final base only shows on the writeback pulse, one cycle after the last accepted beat.

Interleaving stalls with accepts exposes any state that advances without a handshake. This is visible on the same beat.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'd0,
    MODE_INC_BEFORE = 2'd1,
    MODE_DEC_AFTER  = 2'd2,
    MODE_DEC_BEFORE = 2'd3
  } lsm_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } lsm_state_e;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CNT_W'(vec_i[i]);
    end
  end
endmodule

// File: rtl/lsm_lowest_pick.sv
module lsm_lowest_pick #(
  parameter int W = 16,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             last_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o  = |vec_i;
  // single bit left: clearing lowest set bit yields zero
  assign last_o = any_o && ((vec_i & (vec_i - W'(1))) == '0);
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] final_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  lsm_mode_e          mode;
  logic [ADDR_W-1:0]  span;

  assign mode = lsm_mode_e'(mode_i);
  assign span = ADDR_W'(cnt_i) * STEP_V;

  always_comb begin
    unique case (mode)
      MODE_INC_AFTER: begin
        first_o = base_i;
        final_o = base_i + span;
      end
      MODE_INC_BEFORE: begin
        first_o = base_i + STEP_V;
        final_o = base_i + span;
      end
      MODE_DEC_AFTER: begin
        first_o = base_i - span + STEP_V;
        final_o = base_i - span;
      end
      default: begin
        first_o = base_i - span;
        final_o = base_i - span;
      end
    endcase
  end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NREG-1:0]   reg_list_i,
  input  logic [1:0]        mode_i,
  input  logic              wb_en_i,
  output logic              busy_o,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [IDX_W-1:0]  beat_reg_o,
  output logic              beat_last_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_base_o
);
  lsm_state_e        state_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wb_base_q;
  logic              wb_en_q;

  logic [CNT_W-1:0]  req_cnt;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] final_base;
  logic [IDX_W-1:0]  cur_idx;
  logic              mask_any;
  logic              mask_last;
  logic              accept;

  lsm_popcnt #(.W(NREG)) u_popcnt (
    .vec_i (reg_list_i),
    .cnt_o (req_cnt)
  );

  lsm_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_plan (
    .base_i  (base_i),
    .cnt_i   (req_cnt),
    .mode_i  (mode_i),
    .first_o (first_addr),
    .final_o (final_base)
  );

  lsm_lowest_pick #(.W(NREG)) u_pick (
    .vec_i  (mask_q),
    .idx_o  (cur_idx),
    .any_o  (mask_any),
    .last_o (mask_last)
  );

  assign accept = (state_q == ST_RUN) && beat_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mask_q    <= '0;
      addr_q    <= '0;
      wb_base_q <= '0;
      wb_en_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mask_q    <= reg_list_i;
            addr_q    <= first_addr;
            wb_base_q <= final_base;
            wb_en_q   <= wb_en_i;
            state_q   <= (|reg_list_i) ? ST_RUN : ST_DONE;
          end
        end
        ST_RUN: begin
          if (accept) begin
            mask_q <= mask_q & (mask_q - NREG'(1));
            addr_q <= addr_q + ADDR_W'(STEP);
            if (mask_last || !mask_any) state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign beat_valid_o = (state_q == ST_RUN);
  assign beat_addr_o  = addr_q;
  assign beat_reg_o   = cur_idx;
  assign beat_last_o  = (state_q == ST_RUN) && mask_last;
  assign wb_valid_o   = (state_q == ST_DONE) && wb_en_q;
  assign wb_base_o    = wb_base_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int STEP   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [ADDR_W-1:0] beat_addr_o,
  input logic [IDX_W-1:0]  beat_reg_o,
  input logic              beat_last_o,
  input logic              wb_valid_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!beat_valid_o && !wb_valid_o));

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i) |=>
      (beat_valid_o && $stable(beat_addr_o) && $stable(beat_reg_o)));

  assert_step_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && !beat_last_o) |=>
      (beat_valid_o && beat_addr_o == $past(beat_addr_o) + ADDR_W'(STEP)
       && beat_reg_o > $past(beat_reg_o)));

  assert_last_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && beat_last_o) |=> (!beat_valid_o && busy_o));

  assert_wb_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(beat_valid_o && wb_valid_o));

  assert_wb_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !busy_o);
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STEP(STEP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_addr_o  (beat_addr_o),
  .beat_reg_o   (beat_reg_o),
  .beat_last_o  (beat_last_o),
  .wb_valid_o   (wb_valid_o)
);

// File: tb/tb_lsm_addr_seq.sv
`timescale 1ns/1ps
module tb_lsm_addr_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reg_list_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_en_i = 1'b0;
  logic        busy_o, beat_valid_o, beat_ready_i, beat_last_o, wb_valid_o;
  logic [31:0] beat_addr_o, wb_base_o;
  logic [3:0]  beat_reg_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] last_wb;

  always #5 clk_i = ~clk_i;

  lsm_addr_seq dut (
    .clk_i, .rst_ni, .start_i, .base_i, .reg_list_i, .mode_i, .wb_en_i,
    .busy_o, .beat_valid_o, .beat_ready_i, .beat_addr_o, .beat_reg_o,
    .beat_last_o, .wb_valid_o, .wb_base_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // issue one request and follow it to completion
  task automatic run_seq(input logic [31:0] base, input logic [15:0] list,
                         input logic [1:0] mode, input bit wb, input bit stall,
                         input bit poke, input string req);
    int n = 0, k = 0, wbs = 0, cyc = 0;
    bit held = 0;
    logic [31:0] lo, fin, h_addr, exp_a;
    logic [3:0] h_reg;
    int exp_r[16];
    for (int i = 0; i < 16; i++) if (list[i]) begin exp_r[n] = i; n++; end
    if (mode[1]) begin
      lo = base - 32'(4 * n) + (mode[0] ? 32'd0 : 32'd4);
      fin = base - 32'(4 * n);
    end else begin
      lo = base + (mode[0] ? 32'd4 : 32'd0);
      fin = base + 32'(4 * n);
    end
    @(negedge clk_i);
    base_i = base; reg_list_i = list; mode_i = mode; wb_en_i = wb; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o && cyc < 100) begin
      if (poke) begin
        start_i = beat_valid_o; base_i = 32'hDEAD0000; reg_list_i = 16'h0001;
        mode_i = 2'd3;  // R8 stimulus
      end
      if (beat_valid_o) begin
        if (held) begin
          check(beat_addr_o == h_addr && beat_reg_o == h_reg, "R5", "hold", beat_addr_o, h_addr);
          held = 0;
        end
        if (stall && (cyc % 2 == 0)) begin
          beat_ready_i = 1'b0; held = 1; h_addr = beat_addr_o; h_reg = beat_reg_o;
        end else begin
          beat_ready_i = 1'b1;
          exp_a = lo + 32'(4 * k);
          check(beat_addr_o == exp_a, req, "beat addr", beat_addr_o, exp_a);
          check(k < n && beat_reg_o == 4'(exp_r[k]), "R4", "beat reg", 32'(beat_reg_o), 32'(exp_r[k]));
          check(beat_last_o == (k == n - 1), "R9", "last flag", 32'(beat_last_o), 32'(k == n - 1));
          k++;
        end
      end
      if (wb_valid_o) begin
        wbs++;
        last_wb = wb_base_o;
        check(wb_base_o == fin, n == 0 ? "R7" : "R6", "wb base", wb_base_o, fin);
        check(k == n, "R6", "wb after last beat", 32'(k), 32'(n));
      end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    beat_ready_i = 1'b1;
    check(k == n, n == 0 ? "R7" : "R4", "beat count", 32'(k), 32'(n));
    check(wbs == (wb ? 1 : 0), "R6", "wb pulses", 32'(wbs), 32'(wb ? 1 : 0));
    check(!busy_o && !beat_valid_o, poke ? "R8" : "R9", "idle after", 32'(busy_o), 32'd0);
  endtask

  task automatic test_reset();
    beat_ready_i = 1'b1;
    #1;
    check(!busy_o && !beat_valid_o && !wb_valid_o, "R1", "in reset", 32'(busy_o), 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !beat_valid_o && !wb_valid_o, "R1", "after reset", 32'(beat_valid_o), 32'd0);
  endtask

  task automatic test_inc_modes();
    run_seq(32'h0008_0010, 16'h000E, 2'd0, 1, 0, 0, "R2");
    check(last_wb == 32'h0008_001C, "R6", "IA wb", last_wb, 32'h0008_001C);
    run_seq(32'h0000_1000, 16'h8000, 2'd0, 0, 1, 0, "R2");
    run_seq(32'h0000_2000, 16'h0A51, 2'd1, 1, 1, 0, "R2");
  endtask

  task automatic test_dec_modes();
    run_seq(32'h0000_3000, 16'hFFFF, 2'd3, 1, 1, 0, "R3");
    run_seq(32'h0000_4000, 16'h8001, 2'd2, 1, 0, 0, "R3");
  endtask

  task automatic test_stack();
    run_seq(32'h0008_0014, 16'h0012, 2'd3, 1, 0, 0, "R10");
    check(last_wb == 32'h0008_000C, "R10", "push wb", last_wb, 32'h0008_000C);
    run_seq(32'h0000_9000, 16'h000E, 2'd1, 1, 0, 0, "R10");
    check(last_wb == 32'h0000_900C, "R10", "IB wb", last_wb, 32'h0000_900C);
    run_seq(last_wb, 16'h000E, 2'd2, 1, 1, 0, "R10");
    check(last_wb == 32'h0000_9000, "R10", "DA restore", last_wb, 32'h0000_9000);
  endtask

  task automatic test_empty();
    run_seq(32'h0000_5000, 16'h0000, 2'd3, 1, 0, 0, "R7");
    check(last_wb == 32'h0000_5000, "R7", "empty base", last_wb, 32'h0000_5000);
    run_seq(32'h0000_5000, 16'h0000, 2'd0, 0, 0, 0, "R7");
  endtask

  task automatic test_busy_start();
    run_seq(32'h0000_6000, 16'h00F0, 2'd0, 1, 1, 1, "R8");
  endtask

  initial begin
    #200000ns;
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", n_checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_inc_modes();
    test_dec_modes();
    test_stack();
    test_empty();
    test_busy_start();
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule